// File: doc/BRIEF.md
# I2C Slave Transmitter with Status-Code Handshake

This block is a two-wire slave that answers read requests from an external bus master. It watches the open-drain SCL and SDA lines through synchronizers and compares each address byte against a 7-bit own address supplied by the host. When the address matches and the direction bit asks for a read, the block acknowledges. It then reports each step of the transfer to the host as an 8-bit status code together with an interrupt flag.

While the flag is set the block holds SCL low, which stalls the master. The host reads the status code, places the next byte on `tx_data_i` and pulses `flag_clr_i`. The block then shifts that byte out MSB first. Clearing `ack_en_i` before a byte is loaded makes that byte the last one of the transfer. Clearing it also hides the block from its own address until the bit is set again.

A START or STOP that lands inside an address byte, a data byte or an acknowledge bit is reported as a bus error. The host clears a bus error by setting a stop request and then clearing the flag. This returns the block to the idle state with both lines released.

Top module: `i2c_slv_tx`

## Requirements
- R1: After reset, `irq_o`=0, `status_o`=F8h, `stop_o`=0, and neither `scl_low_o` nor `sda_low_o` is asserted.
- R2: An address byte whose upper 7 bits equal `own_addr_i` and whose last bit is 1, received while `ack_en_i`=1, is acknowledged by driving SDA low during the 9th clock. On the falling SCL edge after that clock, `irq_o` becomes 1, `status_o` becomes A8h and SCL is held low.
- R3: No acknowledge and no flag follow an address byte in three cases: the address differs, the last bit is 0 (write), or `ack_en_i`=0. Once `ack_en_i` is 1 again, the own address is acknowledged on the next transfer.
- R4: A `flag_clr_i` pulse while the status is A8h or B8h samples `tx_data_i`, releases SCL and sends that byte MSB first over the next 8 SCL clocks.
- R5: After each sent byte the block samples the master's acknowledge bit and sets the flag on the following SCL fall. The status is C0h when the master answered NACK. It is C8h when the master answered ACK and `ack_en_i` was 0 when the byte was loaded. Otherwise it is B8h.
- R6: A `flag_clr_i` pulse while the status is C0h or C8h makes the block not addressed. SDA then stays released, so further master clocks read all ones, and no new flag is raised.
- R7: `status_o` is F8h whenever `irq_o` is 0.
- R8: A START or STOP detected in any of four places sets `irq_o` with `status_o`=00h and holds SCL low: an address byte after its first bit, the address acknowledge bit, a data byte, or a data acknowledge bit.
- R9: While a bus error is pending, a `flag_clr_i` pulse with `stop_o`=0 has no effect: `irq_o` stays 1 and `status_o` stays 00h.
- R10: After `stop_set_i` sets `stop_o`, a `flag_clr_i` pulse during a bus error has four effects on the next cycle. It clears `irq_o` and clears `stop_o`. It returns `status_o` to F8h. It releases both SCL and SDA without producing a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Pull SCL low when 1 (open drain) |
| sda_low_o | output | 1 | Pull SDA low when 1 (open drain) |
| own_addr_i | input | 7 | Own 7-bit slave address |
| ack_en_i | input | 1 | Acknowledge enable; 0 ends the read after the next byte and detaches the slave |
| tx_data_i | input | 8 | Next byte to send, sampled when the flag is cleared |
| flag_clr_i | input | 1 | One-cycle pulse that clears the interrupt flag |
| stop_set_i | input | 1 | One-cycle pulse that sets the stop request used for bus-error recovery |
| irq_o | output | 1 | Interrupt flag |
| status_o | output | 8 | Status code |
| stop_o | output | 1 | Stop request bit, cleared by the block on recovery |

## Verification
Every bus event reaches the core on the second rising clock edge after the line changes, because it passes two synchronizer stages and an edge register. `irq_o`, `status_o` and the SDA/SCL drive outputs therefore update on the third rising edge after the SCL edge that causes them. SCL is released two edges after the `flag_clr_i` pulse, with one load cycle in between. The bench master samples SDA a half period plus a quarter period after each SCL fall, which is far past that latency. The bench checks flag and status eight clocks after the master's edge and samples on the falling clock edge. Host-side results such as a blocked clear or a recovery are checked two clocks after the pulse.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_LOAD, ST_TX, ST_DACK, ST_WAIT, ST_ERR
  } slv_state_e;

  localparam logic [7:0] SC_SLA_R    = 8'hA8;
  localparam logic [7:0] SC_TX_ACK   = 8'hB8;
  localparam logic [7:0] SC_TX_NACK  = 8'hC0;
  localparam logic [7:0] SC_LAST_ACK = 8'hC8;
  localparam logic [7:0] SC_BUS_ERR  = 8'h00;
  localparam logic [7:0] SC_NONE     = 8'hF8;
endpackage

// File: rtl/i2c_slv_cond.sv
module i2c_slv_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sync, sda_sync;
  logic scl_d, sda_d, scl_s, sda_s;

  // idle-high reset avoids phantom edges after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[LAST-1:0], scl_i};
      sda_sync <= {sda_sync[LAST-1:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s      = scl_sync[LAST];
  assign sda_s      = sda_sync[LAST];
  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_slv_core.sv
module i2c_slv_core
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              flag_clr_i,
  input  logic              stop_set_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  output logic              irq_o,
  output logic [7:0]        status_o,
  output logic              stop_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              last_q, last_d;
  logic              mack_q, mack_d;
  logic              sda_oe_q, sda_oe_d;
  logic              irq_q, status_set, flag_clr_ok;
  logic [7:0]        status_q, code;
  logic              stop_q, recover;
  logic              err_cond, addr_hit;

  assign addr_hit = (sh_q[DATA_W-1:DATA_W-ADDR_W] == own_addr_i) && sh_q[0] && ack_en_i;

  assign err_cond = (start_i | stop_i) &&
                    ((state_q == ST_ADDR && cnt_q != '0) || state_q == ST_AACK ||
                     state_q == ST_TX || state_q == ST_DACK);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    sh_d        = sh_q;
    last_d      = last_q;
    mack_d      = mack_q;
    sda_oe_d    = sda_oe_q;
    status_set  = 1'b0;
    code        = SC_NONE;
    flag_clr_ok = 1'b0;
    recover     = 1'b0;
    if (err_cond) begin
      state_d    = ST_ERR;
      sda_oe_d   = 1'b0;
      status_set = 1'b1;
      code       = SC_BUS_ERR;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          sda_oe_d = 1'b0;
          if (start_i) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
          end
        end
        ST_ADDR: begin
          if (start_i) begin
            cnt_d = '0;
          end else if (stop_i) begin
            state_d = ST_IDLE;
          end else if (scl_rise_i && cnt_q < CNT_FULL) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_FULL) begin
            if (addr_hit) begin
              state_d  = ST_AACK;
              sda_oe_d = 1'b1;
            end else begin
              state_d  = ST_IDLE;
              sda_oe_d = 1'b0;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall_i) begin
            sda_oe_d   = 1'b0;
            status_set = 1'b1;
            code       = SC_SLA_R;
            state_d    = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (flag_clr_i) begin
            flag_clr_ok = 1'b1;
            if (status_q == SC_SLA_R || status_q == SC_TX_ACK) begin
              state_d  = ST_LOAD;
              sh_d     = tx_data_i;
              last_d   = ~ack_en_i;
              sda_oe_d = ~tx_data_i[DATA_W-1];
              cnt_d    = '0;
            end else begin
              state_d  = ST_IDLE;
              sda_oe_d = 1'b0;
            end
          end
        end
        ST_LOAD: state_d = ST_TX;  // SDA settles one cycle before SCL is released
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == CNT_LAST) begin
              state_d  = ST_DACK;
              sda_oe_d = 1'b0;
              cnt_d    = '0;
            end else begin
              sh_d     = {sh_q[DATA_W-2:0], 1'b0};
              sda_oe_d = ~sh_q[DATA_W-2];
              cnt_d    = cnt_q + 1'b1;
            end
          end
        end
        ST_DACK: begin
          if (scl_rise_i) mack_d = ~sda_s_i;
          if (scl_fall_i) begin
            status_set = 1'b1;
            code       = !mack_q ? SC_TX_NACK : (last_q ? SC_LAST_ACK : SC_TX_ACK);
            state_d    = ST_WAIT;
          end
        end
        ST_ERR: begin
          if (flag_clr_i && stop_q) begin
            flag_clr_ok = 1'b1;
            recover     = 1'b1;
            state_d     = ST_IDLE;
            sda_oe_d    = 1'b0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      last_q   <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      last_q   <= last_d;
      mack_q   <= mack_d;
      sda_oe_q <= sda_oe_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          irq_q <= 1'b0;
    else if (status_set)  irq_q <= 1'b1;
    else if (flag_clr_ok) irq_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          status_q <= SC_NONE;
    else if (status_set)  status_q <= code;
    else if (flag_clr_ok) status_q <= SC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stop_q <= 1'b0;
    else if (recover)    stop_q <= 1'b0;
    else if (stop_set_i) stop_q <= 1'b1;
  end

  assign scl_low_o = irq_q | (state_q == ST_LOAD);
  assign sda_low_o = sda_oe_q;
  assign irq_o     = irq_q;
  assign status_o  = status_q;
  assign stop_o    = stop_q;

  a_r7_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_q |-> status_q == SC_NONE);
  a_r2_sla_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AACK && scl_fall_i && !start_i && !stop_i) |=> (irq_q && status_q == SC_SLA_R));
  a_r8_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_ERR |-> (irq_q && status_q == SC_BUS_ERR));
  a_r9_clr_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR && flag_clr_i && !stop_q) |=> (state_q == ST_ERR && irq_q));
  a_r10_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR && flag_clr_i && stop_q) |=>
      (!irq_q && !stop_q && !sda_oe_q && state_q == ST_IDLE));
  a_r6_idle_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_q);
endmodule

// File: rtl/i2c_slv_tx.sv
module i2c_slv_tx #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              flag_clr_i,
  input  logic              stop_set_i,
  output logic              irq_o,
  output logic [7:0]        status_o,
  output logic              stop_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_slv_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_slv_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .own_addr_i (own_addr_i),
    .ack_en_i   (ack_en_i),
    .tx_data_i  (tx_data_i),
    .flag_clr_i (flag_clr_i),
    .stop_set_i (stop_set_i),
    .scl_low_o  (scl_low_o),
    .sda_low_o  (sda_low_o),
    .irq_o      (irq_o),
    .status_o   (status_o),
    .stop_o     (stop_o)
  );
endmodule

// File: tb/tb_i2c_slv_tx.sv
`timescale 1ns/1ps
module tb_i2c_slv_tx;
  localparam int HALF = 12;
  localparam int WD   = 150000;
  localparam logic [6:0] OWN = 7'h3A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic ack_en = 1'b1, flag_clr = 1'b0, stop_set = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic scl_low, sda_low, irq, stop_bit;
  logic [7:0] status;
  logic scl_line, sda_line;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign scl_line = ~(scl_low | m_scl_low);
  assign sda_line = ~(sda_low | m_sda_low);

  i2c_slv_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_line), .sda_i(sda_line),
    .scl_low_o(scl_low), .sda_low_o(sda_low), .own_addr_i(OWN), .ack_en_i(ack_en),
    .tx_data_i(tx_data), .flag_clr_i(flag_clr), .stop_set_i(stop_set),
    .irq_o(irq), .status_o(status), .stop_o(stop_bit)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda_low = ~b;
    wait_cyc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(HALF / 2);
    r = sda_line;
    wait_cyc(HALF / 2);
    m_scl_low = 1'b1;
  endtask

  task automatic m_start();
    m_sda_low = 1'b1;
    wait_cyc(HALF);
    m_scl_low = 1'b1;
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    wait_cyc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(HALF);
    m_sda_low = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack_bit);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
    clk_bit(1'b1, ack_bit);
  endtask

  task automatic read_byte(output logic [7:0] v, input logic give_ack);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      v[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  task automatic host_clear();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    wait_cyc(2);
  endtask

  task automatic open_read(input string tag);
    logic a;
    m_start();
    write_byte({OWN, 1'b1}, a);
    check({tag, " R2 addr ack"}, {7'd0, a}, 8'h00);
    wait_cyc(8);
    check({tag, " R2 irq"}, {7'd0, irq}, 8'h01);
    check({tag, " R2 status A8"}, status, 8'hA8);
  endtask

  task automatic t_reset();
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 R7 status", status, 8'hF8);
    check("R1 stop", {7'd0, stop_bit}, 8'h00);
    check("R1 scl_low", {7'd0, scl_low}, 8'h00);
    check("R1 sda_low", {7'd0, sda_low}, 8'h00);
  endtask

  task automatic t_normal_read();
    logic [7:0] v;
    open_read("normal");
    check("R2 scl held", {7'd0, scl_line}, 8'h00);
    tx_data = 8'hC3;
    host_clear();
    read_byte(v, 1'b1);
    check("R4 byte0", v, 8'hC3);
    wait_cyc(8);
    check("R5 status B8", status, 8'hB8);
    tx_data = 8'h5A;
    host_clear();
    read_byte(v, 1'b0);
    check("R4 byte1", v, 8'h5A);
    wait_cyc(8);
    check("R5 status C0", status, 8'hC0);
    host_clear();
    check("R6 R7 idle status", status, 8'hF8);
    read_byte(v, 1'b0);
    check("R6 all ones", v, 8'hFF);
    wait_cyc(8);
    check("R6 no flag", {7'd0, irq}, 8'h00);
    m_stop();
  endtask

  task automatic t_early_end();
    logic [7:0] v;
    open_read("early");
    tx_data = 8'h96;
    ack_en = 1'b0;
    host_clear();
    read_byte(v, 1'b1);
    check("R4 last byte", v, 8'h96);
    wait_cyc(8);
    check("R5 status C8", status, 8'hC8);
    host_clear();
    read_byte(v, 1'b1);
    check("R6 ones after C8", v, 8'hFF);
    check("R6 no flag after C8", {7'd0, irq}, 8'h00);
    m_stop();
  endtask

  task automatic t_detach_resume();
    logic a;
    logic [7:0] v;
    m_start();
    write_byte({OWN, 1'b1}, a);
    check("R3 detached nack", {7'd0, a}, 8'h01);
    wait_cyc(8);
    check("R3 detached no flag", {7'd0, irq}, 8'h00);
    m_stop();
    ack_en = 1'b1;
    open_read("resume R3");
    tx_data = 8'h01;
    host_clear();
    read_byte(v, 1'b0);
    check("R4 resume byte", v, 8'h01);
    wait_cyc(8);
    check("R5 resume C0", status, 8'hC0);
    host_clear();
    m_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    m_start();
    write_byte({7'h11, 1'b1}, a);
    check("R3 other addr nack", {7'd0, a}, 8'h01);
    wait_cyc(8);
    check("R3 other addr no flag", {7'd0, irq}, 8'h00);
    m_stop();
    m_start();
    write_byte({OWN, 1'b0}, a);
    check("R3 write nack", {7'd0, a}, 8'h01);
    wait_cyc(8);
    check("R3 write no flag", {7'd0, irq}, 8'h00);
    m_stop();
  endtask

  task automatic recover(input string tag);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    wait_cyc(2);
    check({tag, " R9 irq kept"}, {7'd0, irq}, 8'h01);
    check({tag, " R9 status kept"}, status, 8'h00);
    stop_set = 1'b1;
    @(negedge clk);
    stop_set = 1'b0;
    check({tag, " R10 stop set"}, {7'd0, stop_bit}, 8'h01);
    host_clear();
    check({tag, " R10 irq"}, {7'd0, irq}, 8'h00);
    check({tag, " R10 stop cleared"}, {7'd0, stop_bit}, 8'h00);
    check({tag, " R10 R7 status"}, status, 8'hF8);
    check({tag, " R10 lines"}, {6'd0, scl_low, sda_low}, 8'h00);
  endtask

  task automatic t_err_addr();
    logic r;
    m_start();
    clk_bit(1'b0, r);
    clk_bit(1'b1, r);
    clk_bit(1'b1, r);
    m_sda_low = 1'b1;
    wait_cyc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(HALF / 2);
    m_sda_low = 1'b0;
    wait_cyc(8);
    check("R8 addr err irq", {7'd0, irq}, 8'h01);
    check("R8 addr err status", status, 8'h00);
    check("R8 addr err scl held", {7'd0, scl_low}, 8'h01);
    recover("addr");
    wait_cyc(HALF);
  endtask

  task automatic t_err_data();
    logic r;
    open_read("err data");
    tx_data = 8'hFF;
    host_clear();
    clk_bit(1'b1, r);
    clk_bit(1'b1, r);
    wait_cyc(HALF);
    m_scl_low = 1'b0;
    while (!scl_line) @(negedge clk);
    wait_cyc(HALF / 2);
    m_sda_low = 1'b1;
    wait_cyc(8);
    check("R8 data err irq", {7'd0, irq}, 8'h01);
    check("R8 data err status", status, 8'h00);
    recover("data");
    m_sda_low = 1'b0;
    wait_cyc(HALF);
    check("R10 stays idle", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(4);
    t_reset();
    t_normal_read();
    t_early_end();
    t_detach_resume();
    t_mismatch();
    t_err_addr();
    t_err_data();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1-R10 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule